// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table held in memory. A caller gives it the address, the access direction (read or write) and the privilege (user or supervisor), together with the base address of the top-level table. The walker reads the directory entry and then, when needed, the leaf entry. It checks the present and permission bits at each level and marks the entries used. At the end it either returns the physical address or raises a fault that carries a precise syndrome.

Accessed and dirty marking is done by read-modify-write on the same memory port. An entry is written back only when the marking changes it. A directory entry can describe a 4 MB page directly, and in that case the walk ends after one level. The memory side is a plain request/acknowledge port: the walker holds a request steady until it is acknowledged, and read data comes back in the acknowledge cycle. Only one walk is handled at a time.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and just after it, `busy`, `done`, `fault` and `mem_req` are all 0.
- R2: The first memory access of a walk is a read (`mem_we`=0) at `{dir_base[31:12], vaddr[31:22], 2'b00}`. Bits 11:0 of `dir_base` are ignored.
- R3: When the directory entry passes its checks and its bit 6 (large-page flag) is 0, the walker reads the leaf at `{pde[31:12], vaddr[21:12], 2'b00}`.
- R4: A walk that succeeds through a leaf gives `res_paddr = {pte[31:12], vaddr[11:0]}` and `res_ppn = pte[31:12]` during the `done` pulse.
- R5: A directory entry that passes its checks and has bit 6 set ends the walk with no leaf read. The result is `res_paddr = {pde[31:22], vaddr[21:0]}`.
- R6: An entry with bit 0 (present) = 0 at either level ends the walk with `fault`. The syndrome is `flt_not_present`=1, `flt_vaddr` = the request address, and `flt_write`/`flt_user` = the request's direction and privilege. No write-back is made.
- R7: An entry that is present fails on permission when a write meets bit 1 (writable) = 0, or when a user access meets bit 2 (user-allowed) = 0. The walk then ends with `fault` and `flt_not_present`=0. The directory is checked before the leaf is read, so a failing directory always faults with no leaf access.
- R8: Every entry that passes its checks gets bit 5 (accessed) set. A leaf used by a write also gets bit 6 (dirty) set. A directory entry never has bit 6 changed. No other bit changes.
- R9: The marked entry is written back to the address it was read from, right after its read, and only when marking changes it. A walk therefore makes the access sequence dir-read, [dir-write], [leaf-read, [leaf-write]].
- R10: `busy` is 1 from the cycle after a request is accepted until the cycle that `done` or `fault` rises. Requests seen while busy are ignored. `done` and `fault` are single-cycle pulses that never occur together.
- R11: A memory request keeps `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` unchanged until the cycle in which `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a walk (taken only when not busy) |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access |
| req_user | input | 1 | 1 for a user-mode access |
| dir_base | input | 32 | Base address of the top-level table |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse: translation ready |
| fault | output | 1 | One-cycle pulse: walk failed |
| res_paddr | output | 32 | Translated physical address |
| res_ppn | output | 20 | Physical page number of the result |
| flt_vaddr | output | 32 | Faulting virtual address |
| flt_not_present | output | 1 | 1 = entry absent, 0 = permission failure |
| flt_write | output | 1 | Direction of the faulting access |
| flt_user | output | 1 | Privilege of the faulting access |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write-back, 0 = read |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_ack | input | 1 | Memory completes the request |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
The assertions assume a memory that raises `mem_ack` only while `mem_req` is high, gives one acknowledge per request, and presents read data in that same cycle. The bench's memory model keeps to this by acknowledging each new request exactly one cycle after it appears and never acknowledging twice in a row. The write-back checks also assume that nothing else changes a table entry during a walk. The bench touches table words only between walks.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  localparam int unsigned VA_W    = 32;
  localparam int unsigned ENT_W   = 32;
  localparam int unsigned OFF_W   = 12;
  localparam int unsigned IDX_W   = 10;
  localparam int unsigned FRAME_W = VA_W - OFF_W;
  localparam int unsigned BIG_W   = VA_W - OFF_W - IDX_W;

  localparam int unsigned BIT_PRES  = 0;
  localparam int unsigned BIT_WROK  = 1;
  localparam int unsigned BIT_USROK = 2;
  localparam int unsigned BIT_ACC   = 5;
  localparam int unsigned BIT_DIRTY = 6;
  localparam int unsigned BIT_BIG   = 6;

  typedef enum logic [2:0] {
    WS_IDLE    = 3'd0,
    WS_RD_DIR  = 3'd1,
    WS_WB_DIR  = 3'd2,
    WS_RD_LEAF = 3'd3,
    WS_WB_LEAF = 3'd4
  } walk_state_t;

  function automatic logic [VA_W-1:0] dir_slot_addr(input logic [FRAME_W-1:0] base_frame,
                                                    input logic [VA_W-1:0] va);
    return {base_frame, va[VA_W-1 -: IDX_W], 2'b00};
  endfunction

  function automatic logic [VA_W-1:0] leaf_slot_addr(input logic [FRAME_W-1:0] tbl_frame,
                                                     input logic [VA_W-1:0] va);
    return {tbl_frame, va[OFF_W +: IDX_W], 2'b00};
  endfunction

  function automatic logic [VA_W-1:0] small_paddr(input logic [ENT_W-1:0] ent,
                                                  input logic [VA_W-1:0] va);
    return {ent[ENT_W-1 -: FRAME_W], va[OFF_W-1:0]};
  endfunction

  function automatic logic [VA_W-1:0] large_paddr(input logic [ENT_W-1:0] ent,
                                                  input logic [VA_W-1:0] va);
    return {ent[ENT_W-1 -: BIG_W], va[OFF_W+IDX_W-1:0]};
  endfunction

  function automatic logic access_ok(input logic [ENT_W-1:0] ent, input logic wr,
                                     input logic usr);
    return !(wr && !ent[BIT_WROK]) && !(usr && !ent[BIT_USROK]);
  endfunction

  function automatic logic [ENT_W-1:0] mark_entry(input logic [ENT_W-1:0] ent,
                                                  input logic wr, input logic leaf);
    logic [ENT_W-1:0] r;
    r = ent;
    r[BIT_ACC] = 1'b1;
    if (leaf && wr) r[BIT_DIRTY] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/pt_entry_eval.sv
module pt_entry_eval
  import pt_walker_pkg::*;
(
  input  logic [ENT_W-1:0] entry,
  input  logic             is_leaf,
  input  logic             acc_write,
  input  logic             acc_user,
  output logic             present,
  output logic             allowed,
  output logic             big_page,
  output logic             changed,
  output logic [ENT_W-1:0] marked
);

  always_comb begin
    present  = entry[BIT_PRES];
    allowed  = access_ok(entry, acc_write, acc_user);
    big_page = !is_leaf && entry[BIT_BIG];
    marked   = mark_entry(entry, acc_write, is_leaf);
    changed  = (marked != entry);
  end

endmodule

// File: rtl/pt_port_drive.sv
module pt_port_drive
  import pt_walker_pkg::*;
(
  input  walk_state_t        state,
  input  logic [VA_W-1:0]    va,
  input  logic [FRAME_W-1:0] base_frame,
  input  logic [FRAME_W-1:0] tbl_frame,
  input  logic [ENT_W-1:0]   wb_value,
  output logic               req,
  output logic               we,
  output logic [VA_W-1:0]    addr,
  output logic [ENT_W-1:0]   wdata
);

  logic at_dir;

  always_comb begin
    at_dir = (state == WS_RD_DIR) || (state == WS_WB_DIR);
    req    = (state != WS_IDLE);
    we     = (state == WS_WB_DIR) || (state == WS_WB_LEAF);
    addr   = at_dir ? dir_slot_addr(base_frame, va) : leaf_slot_addr(tbl_frame, va);
    wdata  = wb_value;
  end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic               req_write,
  input  logic               req_user,
  input  logic [VA_W-1:0]    dir_base,
  output logic               busy,
  output logic               done,
  output logic               fault,
  output logic [VA_W-1:0]    res_paddr,
  output logic [FRAME_W-1:0] res_ppn,
  output logic [VA_W-1:0]    flt_vaddr,
  output logic               flt_not_present,
  output logic               flt_write,
  output logic               flt_user,
  output logic               mem_req,
  output logic               mem_we,
  output logic [VA_W-1:0]    mem_addr,
  output logic [ENT_W-1:0]   mem_wdata,
  input  logic               mem_ack,
  input  logic [ENT_W-1:0]   mem_rdata
);

  walk_state_t        state_q;
  logic [VA_W-1:0]    va_q;
  logic               wr_q, usr_q;
  logic [FRAME_W-1:0] base_q, tbl_q;
  logic [ENT_W-1:0]   orig_q, upd_q;
  logic               large_q;
  logic [VA_W-1:0]    paddr_q;
  logic               done_q, fault_q, np_q;

  // evaluation of the entry arriving on the memory port
  logic             e_present, e_allowed, e_big, e_changed;
  logic [ENT_W-1:0] e_marked;
  logic             at_leaf;

  // named events for the checker
  logic ev_accept, ev_rd_done, ev_wb_done, ev_leaf_rd, ev_entry_ok;

  assign at_leaf     = (state_q == WS_RD_LEAF);
  assign ev_accept   = (state_q == WS_IDLE) && req_valid;
  assign ev_rd_done  = mem_ack && ((state_q == WS_RD_DIR) || (state_q == WS_RD_LEAF));
  assign ev_wb_done  = mem_ack && ((state_q == WS_WB_DIR) || (state_q == WS_WB_LEAF));
  assign ev_leaf_rd  = (state_q == WS_RD_LEAF);
  assign ev_entry_ok = ev_rd_done && e_present && e_allowed;

  pt_entry_eval u_eval (
    .entry     (mem_rdata),
    .is_leaf   (at_leaf),
    .acc_write (wr_q),
    .acc_user  (usr_q),
    .present   (e_present),
    .allowed   (e_allowed),
    .big_page  (e_big),
    .changed   (e_changed),
    .marked    (e_marked)
  );

  pt_port_drive u_port (
    .state      (state_q),
    .va         (va_q),
    .base_frame (base_q),
    .tbl_frame  (tbl_q),
    .wb_value   (upd_q),
    .req        (mem_req),
    .we         (mem_we),
    .addr       (mem_addr),
    .wdata      (mem_wdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WS_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      usr_q   <= 1'b0;
      base_q  <= '0;
      tbl_q   <= '0;
      orig_q  <= '0;
      upd_q   <= '0;
      large_q <= 1'b0;
      paddr_q <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      np_q    <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      unique case (state_q)
        WS_IDLE: begin
          if (ev_accept) begin
            va_q    <= req_vaddr;
            wr_q    <= req_write;
            usr_q   <= req_user;
            base_q  <= dir_base[VA_W-1:OFF_W];
            large_q <= 1'b0;
            state_q <= WS_RD_DIR;
          end
        end
        WS_RD_DIR, WS_RD_LEAF: begin
          if (mem_ack) begin
            if (!e_present || !e_allowed) begin
              fault_q <= 1'b1;
              np_q    <= !e_present;
              state_q <= WS_IDLE;
            end else begin
              orig_q <= mem_rdata;
              upd_q  <= e_marked;
              if (!at_leaf) begin
                tbl_q   <= mem_rdata[ENT_W-1 -: FRAME_W];
                large_q <= e_big;
                paddr_q <= large_paddr(mem_rdata, va_q);
                if (e_changed)  state_q <= WS_WB_DIR;
                else if (e_big) begin
                  done_q  <= 1'b1;
                  state_q <= WS_IDLE;
                end else        state_q <= WS_RD_LEAF;
              end else begin
                paddr_q <= small_paddr(mem_rdata, va_q);
                if (e_changed) state_q <= WS_WB_LEAF;
                else begin
                  done_q  <= 1'b1;
                  state_q <= WS_IDLE;
                end
              end
            end
          end
        end
        WS_WB_DIR: begin
          if (mem_ack) begin
            if (large_q) begin
              done_q  <= 1'b1;
              state_q <= WS_IDLE;
            end else state_q <= WS_RD_LEAF;
          end
        end
        WS_WB_LEAF: begin
          if (mem_ack) begin
            done_q  <= 1'b1;
            state_q <= WS_IDLE;
          end
        end
        default: state_q <= WS_IDLE;
      endcase
    end
  end

  assign busy            = (state_q != WS_IDLE);
  assign done            = done_q;
  assign fault           = fault_q;
  assign res_paddr       = paddr_q;
  assign res_ppn         = paddr_q[VA_W-1:OFF_W];
  assign flt_vaddr       = va_q;
  assign flt_not_present = np_q;
  assign flt_write       = wr_q;
  assign flt_user        = usr_q;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk
  import pt_walker_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             fault,
  input logic             mem_req,
  input logic             mem_ack,
  input logic             mem_we,
  input logic [VA_W-1:0]  mem_addr,
  input logic [ENT_W-1:0] mem_wdata,
  input logic [ENT_W-1:0] wb_orig,
  input logic             leaf_rd,
  input logic             large_flag
);

  localparam logic [ENT_W-1:0] MARK_MASK = (ENT_W'(1) << BIT_ACC) | (ENT_W'(1) << BIT_DIRTY);

  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault)); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_FAULT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault); // R10
  AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req); // R10
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata))); // R11
  AST_WB_ONLY_CHANGED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata != wb_orig)); // R9
  AST_WB_MARK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> ((mem_wdata & ~MARK_MASK) == (wb_orig & ~MARK_MASK))); // R8
  AST_BIG_NO_LEAF: assert property (@(posedge clk) disable iff (!rst_n)
    leaf_rd |-> !large_flag); // R5

endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .fault      (fault),
  .mem_req    (mem_req),
  .mem_ack    (mem_ack),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .wb_orig    (orig_q),
  .leaf_rd    (ev_leaf_rd),
  .large_flag (large_q)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic [31:0] dir_base = '0;
  logic        busy, done, fault;
  logic [31:0] res_paddr, flt_vaddr;
  logic [19:0] res_ppn;
  logic        flt_not_present, flt_write, flt_user;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack;
  logic [31:0] mem_rdata;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user), .dir_base(dir_base),
    .busy(busy), .done(done), .fault(fault), .res_paddr(res_paddr), .res_ppn(res_ppn),
    .flt_vaddr(flt_vaddr), .flt_not_present(flt_not_present), .flt_write(flt_write),
    .flt_user(flt_user), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // memory model: 16 KB, acknowledges each new request one cycle later
  logic [31:0] mem [0:4095];
  logic [31:0] log_addr [0:15];
  logic        log_we [0:15];
  int          txn_tot = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        mem_rdata <= mem[mem_addr[13:2]];
        if (mem_we) mem[mem_addr[13:2]] = mem_wdata;
        log_addr[txn_tot % 16] <= mem_addr;
        log_we[txn_tot % 16]   <= mem_we;
        txn_tot <= txn_tot + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_walk(input int i);
    logic        p1, w1, u1, a1, big, p2, w2, u2, a2, d2, wr, usr;
    logic [9:0]  vpn1, vpn2;
    logic [11:0] vpo;
    logic [31:0] va, base, pde, pte, pde_new, pte_new, dir_a, leaf_a, exp_pa;
    int          tbl, dir_w, leaf_w, start, n, ex_n, waited;
    logic [31:0] ex_addr [0:3];
    logic        ex_we [0:3];
    bit          exp_fault, exp_np, got;
    p1 = i[0]; w1 = i[1]; u1 = i[2]; a1 = i[3]; big = i[4];
    p2 = i[5]; w2 = i[6]; u2 = i[7]; a2 = i[8]; d2 = i[9];
    wr = i[10]; usr = i[11];
    vpn1 = 10'((i * 37 + 5) % 1024);
    vpn2 = 10'((i * 91 + 3) % 1024);
    vpo  = 12'((i * 13) % 4096);
    va   = {vpn1, vpn2, vpo};
    base = {14'((i * 173) % 16384), 4'b0001, 2'b01, 12'((i * 29) % 4096)};
    tbl  = 2 + int'(vpn1[0]);
    pde  = {10'((i * 7) % 1024), 10'(tbl), 3'b101, i[2] ^ i[9], 1'b0, big, a1,
            i[7], i[6], u1, w1, p1};
    pte  = {20'((i * 40503 + 11) & 32'hFFFFF), 3'b010, i[3], 1'b0, d2, a2,
            i[1], i[0], u2, w2, p2};
    dir_w  = 1024 + int'(vpn1);
    leaf_w = tbl * 1024 + int'(vpn2);
    mem[dir_w]  = pde;
    mem[leaf_w] = pte;

    // expected behaviour, worked out from the requirements
    dir_a  = (base & 32'hFFFF_F000) + 32'(vpn1) * 4;
    leaf_a = (pde & 32'hFFFF_F000) + 32'(vpn2) * 4;
    pde_new = pde; pte_new = pte;
    ex_n = 0; exp_fault = 1'b0; exp_np = 1'b0; exp_pa = '0;
    ex_addr[ex_n] = dir_a; ex_we[ex_n] = 1'b0; ex_n++;
    if (!p1) begin
      exp_fault = 1'b1; exp_np = 1'b1;
    end else if ((wr && !w1) || (usr && !u1)) begin
      exp_fault = 1'b1;
    end else begin
      pde_new = pde | 32'h20;
      if (pde_new != pde) begin ex_addr[ex_n] = dir_a; ex_we[ex_n] = 1'b1; ex_n++; end
      if (big) begin
        exp_pa = ((pde >> 22) << 22) + (32'(vpn2) << 12) + 32'(vpo);
      end else begin
        ex_addr[ex_n] = leaf_a; ex_we[ex_n] = 1'b0; ex_n++;
        if (!p2) begin
          exp_fault = 1'b1; exp_np = 1'b1;
        end else if ((wr && !w2) || (usr && !u2)) begin
          exp_fault = 1'b1;
        end else begin
          pte_new = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
          if (pte_new != pte) begin ex_addr[ex_n] = leaf_a; ex_we[ex_n] = 1'b1; ex_n++; end
          exp_pa = (pte & 32'hFFFF_F000) + 32'(vpo);
        end
      end
    end

    // drive: request, then a second one during busy that must be ignored
    @(negedge clk);
    start = txn_tot;
    req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = usr; dir_base = base;
    @(negedge clk);
    chk(busy === 1'b1, "R10 busy after accept", 32'(busy), 32'd1);
    req_vaddr = ~va; req_write = ~wr; req_user = ~usr; dir_base = base ^ 32'h0000_3000;
    @(negedge clk);
    req_valid = 1'b0;
    got = 1'b0; waited = 0;
    while (!got && waited < 40) begin
      @(negedge clk);
      waited++;
      if (done || fault) got = 1'b1;
    end
    chk(got, "R10 walk ends", 32'(got), 32'd1);
    if (got) begin
      chk(fault === exp_fault && done === !exp_fault, "R6 R7 outcome kind",
          {30'd0, done, fault}, {30'd0, !exp_fault, exp_fault});
      chk(busy === 1'b0, "R10 idle at end pulse", 32'(busy), 32'd0);
      if (exp_fault) begin
        chk(flt_not_present === exp_np, "R6 R7 fault cause", 32'(flt_not_present), 32'(exp_np));
        chk(flt_vaddr === va && flt_write === wr && flt_user === usr, "R6 fault syndrome",
            flt_vaddr ^ {30'd0, flt_write ^ wr, flt_user ^ usr}, va);
      end else begin
        chk(res_paddr === exp_pa, big ? "R5 large page address" : "R4 leaf address",
            res_paddr, exp_pa);
        chk(res_ppn === exp_pa[31:12], "R4 ppn", 32'(res_ppn), 32'(exp_pa[31:12]));
      end
      @(negedge clk);
      chk(!done && !fault, "R10 single-cycle pulse", {30'd0, done, fault}, 32'd0);
    end
    n = txn_tot - start;
    chk(n == ex_n, "R9 access count", 32'(n), 32'(ex_n));
    if (n == ex_n) begin
      for (int k = 0; k < ex_n; k++) begin
        chk(log_addr[(start + k) % 16] === ex_addr[k] && log_we[(start + k) % 16] === ex_we[k],
            k == 0 ? "R2 dir read" : "R3 R9 access order",
            log_addr[(start + k) % 16], ex_addr[k]);
      end
    end
    chk(mem[dir_w] === pde_new, "R8 dir entry after walk", mem[dir_w], pde_new);
    chk(mem[leaf_w] === pte_new, "R8 leaf entry after walk", mem[leaf_w], pte_new);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R10 actual=%h expected=%h", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4096; k++) mem[k] = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fault && !mem_req, "R1 in reset",
        {28'd0, busy, done, fault, mem_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !fault && !mem_req, "R1 after reset",
        {28'd0, busy, done, fault, mem_req}, 32'd0);
    for (int i = 0; i < 4096; i++) run_walk(i);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule